// File: doc/BRIEF.md
# Packet Command Decoder with Held Command Register

This block sits behind the link receiver of a front-end readout board. It takes two kinds of incoming command. The first kind is a single-byte fast command, which arrives on its own strobe. The second kind is a block-transfer packet, which arrives as a stream of 16-bit words. Fast commands raise pending bits in a fast-command register and drive an acquisition gate. Most fast commands also answer the sender with a short acknowledge packet, unless echo is switched off.

A block-transfer packet has five words: type, identifier, modifier, size and data. The data word must carry exactly one set bit. The modifier picks a target register, and the bit that is set picks the action. Each action sets one bit in a block-transfer pending register. The upper nibble of the type word names the link port the packet came through. The block captures that nibble and leaves it out of the type match. Every pending bit stays set until the user function that serves it clears the bit. A malformed block-transfer packet does nothing except add one to a saturating bad-packet counter.

Top module: `cmd_decoder`

## Requirements
- R1: A fast command sets its bit of `fc_pend` one cycle after the `fc_valid` cycle. The codes map to bits as follows: 0x21 to bit 0 (global reset), 0x22 to bit 1 (internal acquisition start), 0x42 to bit 2 (external acquisition start), 0x62 to bit 3 (acquisition stop), 0x6F to bit 4 (link resume) and 0x8F to bit 5 (link pause).
- R2: `gate_open` is low after reset. It goes high the cycle after code 0x42 and goes low the cycle after code 0x62. No other code changes it.
- R3: For the codes 0x22, 0x42, 0x62, 0x6F and 0x8F, the block emits a two-word acknowledge packet on `ack_valid`/`ack_word`. The first word, 0xBABA, appears the cycle after `fc_valid`. The second word, {8'h00, code}, follows in the next cycle. `ack_valid` then drops. Code 0x21 produces no acknowledge packet.
- R4: While `echo_off` is high in the `fc_valid` cycle, no acknowledge packet is emitted. The pending bit and the gate still act as in R1 and R2.
- R5: A fast code outside the R1 list changes no pending bit and does not change the gate. It also produces no acknowledge packet.
- R6: A packet is a block transfer when the low 12 bits of its first word equal 0x002, word 4 (size) equals 0x0001, and word 5 (data) has exactly one bit set. Such a packet sets one bit of `bt_pend` the cycle after the data word, according to the modifier and the data bit:
  - modifier 0x0004, data bits 0, 1, 2, 3 and 7: `bt_pend` bits 0, 1, 2, 3 and 4;
  - modifier 0x0006, data bit 0: `bt_pend` bit 5;
  - modifier 0x0012, data bits 0 and 1: `bt_pend` bits 6 and 7;
  - modifier 0x001C, data bits 0, 1 and 2: `bt_pend` bits 8, 9 and 10.
- R7: `port_nib` takes bits 15:12 of the first word of every packet. It changes the cycle after that word, whatever the packet type. A nonzero nibble does not prevent a type match.
- R8: A block-transfer-typed packet adds one to `bad_count` the cycle after its data word when its size is not 0x0001, or when its data word has zero set bits or more than one set bit. The counter saturates at all ones. Such a packet sets no pending bit.
- R9: A pending bit in `fc_pend` or `bt_pend` stays set until its bit of `fc_clr` or `bt_clr` is high. A new set in the same cycle as a clear leaves the bit set. After reset both registers are zero and `bad_count` is zero.
- R10: A packet whose first word has low 12 bits other than 0x002 sets no pending bit and does not change `bad_count`.
- R11: A well-formed block transfer changes nothing and is not counted as bad when its modifier is not listed in R6, or when its single data bit is not listed for that modifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fc_valid | input | 1 | Fast command strobe |
| fc_code | input | 8 | Fast command code |
| echo_off | input | 1 | Suppresses acknowledge packets |
| pkt_valid | input | 1 | Packet word valid |
| pkt_first | input | 1 | Marks the first word of a packet |
| pkt_word | input | 16 | Packet word |
| fc_clr | input | 6 | Per-bit clear of fast pending bits |
| bt_clr | input | 11 | Per-bit clear of block-transfer pending bits |
| fc_pend | output | 6 | Pending fast commands |
| bt_pend | output | 11 | Pending block-transfer actions |
| gate_open | output | 1 | Acquisition gate |
| port_nib | output | 4 | Port nibble of the last packet |
| bad_count | output | CNT_W | Saturating count of malformed block transfers |
| ack_valid | output | 1 | Acknowledge word valid |
| ack_word | output | 16 | Acknowledge word |

## Verification
The assertions assume two things about the inputs. Fast commands are at least three cycles apart, so that one acknowledge packet ends before the next one starts. Every packet opens with a word that has `pkt_first` set. The stimulus meets both assumptions because every operation runs as a task that leaves idle cycles before the next one starts. Packet words are sent one per cycle, starting with a marked first word. Random picks choose among listed and unlisted codes and modifiers, one-hot and arbitrary data words, and sizes, and directed cases cover set-versus-clear collisions and counter saturation.

// File: rtl/cmdec_pkg.sv
package cmdec_pkg;
   localparam int FC_N = 6;
   localparam int BT_N = 11;
   localparam int WORD_W = 16;
   localparam logic [7:0] FC_CODES [FC_N] = '{8'h21, 8'h22, 8'h42, 8'h62, 8'h6F, 8'h8F};
   localparam int FC_GATE_ON  = 2;
   localparam int FC_GATE_OFF = 3;
   localparam logic [11:0] BT_TYPE   = 12'h002;
   localparam logic [15:0] MOD_RESET = 16'h0004;
   localparam logic [15:0] MOD_MODE  = 16'h0006;
   localparam logic [15:0] MOD_STAT  = 16'h0012;
   localparam logic [15:0] MOD_BANK  = 16'h001C;
   localparam logic [15:0] ACK_ID    = 16'hBABA;

   typedef enum logic [2:0] {
      W_IDLE = 3'd0, W_ID = 3'd1, W_MOD = 3'd2, W_SIZE = 3'd3, W_DATA = 3'd4, W_DONE = 3'd5
   } wpos_t;
endpackage

// File: rtl/fc_decode.sv
module fc_decode
   import cmdec_pkg::*;
(
   input  logic            valid,
   input  logic [7:0]      code,
   output logic [FC_N-1:0] hit,
   output logic            ack_req
);
   for (genvar i = 0; i < FC_N; i++) begin : g_match
      assign hit[i] = valid && (code == FC_CODES[i]);
   end
   // index 0 (global reset) never requests an acknowledge
   assign ack_req = |hit[FC_N-1:1];
endmodule

// File: rtl/bt_parser.sv
module bt_parser
   import cmdec_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  logic              first,
   input  logic [WORD_W-1:0] word,
   output logic [BT_N-1:0]   set,
   output logic              bad,
   output logic [3:0]        nib
);
   wpos_t       pos;
   logic        type_ok;
   logic        size_ok;
   logic [15:0] mod_q;
   logic        data_cyc;
   logic        onehot;
   logic [BT_N-1:0] mapped;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos     <= W_IDLE;
         type_ok <= 1'b0;
         size_ok <= 1'b0;
         mod_q   <= '0;
         nib     <= '0;
      end else if (valid) begin
         if (first) begin
            pos     <= W_ID;
            type_ok <= (word[11:0] == BT_TYPE);
            nib     <= word[15:12];
         end else begin
            case (pos)
               W_ID:   pos <= W_MOD;
               W_MOD:  begin mod_q <= word; pos <= W_SIZE; end
               W_SIZE: begin size_ok <= (word == 16'h0001); pos <= W_DATA; end
               W_DATA: pos <= W_DONE;
               default: pos <= pos;
            endcase
         end
      end
   end

   assign data_cyc = valid && !first && (pos == W_DATA);
   assign onehot   = ($countones(word) == 1);

   always_comb begin
      mapped = '0;
      case (mod_q)
         MOD_RESET: begin
            mapped[0] = word[0];
            mapped[1] = word[1];
            mapped[2] = word[2];
            mapped[3] = word[3];
            mapped[4] = word[7];
         end
         MOD_MODE: mapped[5] = word[0];
         MOD_STAT: begin
            mapped[6] = word[0];
            mapped[7] = word[1];
         end
         MOD_BANK: mapped[10:8] = word[2:0];
         default:  mapped = '0;
      endcase
   end

   assign set = (data_cyc && type_ok && size_ok && onehot) ? mapped : '0;
   assign bad = data_cyc && type_ok && (!size_ok || !onehot);

   // R6
   one_action_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(set));
   // R8
   bad_no_action_chk: assert property (@(posedge clk) disable iff (!rst_n) bad |-> (set == '0));
endmodule

// File: rtl/ack_gen.sv
module ack_gen
   import cmdec_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig,
   input  logic [7:0]        code,
   output logic              valid,
   output logic [WORD_W-1:0] word
);
   logic       second;
   logic [7:0] code_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid  <= 1'b0;
         word   <= '0;
         second <= 1'b0;
         code_q <= '0;
      end else if (trig) begin
         valid  <= 1'b1;
         word   <= ACK_ID;
         code_q <= code;
         second <= 1'b1;
      end else if (second) begin
         word   <= {8'h00, code_q};
         second <= 1'b0;
      end else begin
         valid  <= 1'b0;
      end
   end

   // R3
   ack_head_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(valid) |-> (word == ACK_ID));
   // R3
   ack_two_words_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && word == ACK_ID) |=> valid);
endmodule

// File: rtl/cmd_decoder.sv
module cmd_decoder
   import cmdec_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter bit AUTO_ACK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fc_valid,
   input  logic [7:0]        fc_code,
   input  logic              echo_off,
   input  logic              pkt_valid,
   input  logic              pkt_first,
   input  logic [15:0]       pkt_word,
   input  logic [5:0]        fc_clr,
   input  logic [10:0]       bt_clr,
   output logic [5:0]        fc_pend,
   output logic [10:0]       bt_pend,
   output logic              gate_open,
   output logic [3:0]        port_nib,
   output logic [CNT_W-1:0]  bad_count,
   output logic              ack_valid,
   output logic [15:0]       ack_word
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   if (CNT_W < 1) begin : g_bad_cnt_w
      $error("CNT_W must be at least 1");
   end
   if (FC_N != 6 || BT_N != 11) begin : g_bad_shape
      $error("command register widths do not match the port list");
   end

   logic [FC_N-1:0] fc_hit;
   logic            ack_req;
   logic [BT_N-1:0] bt_set;
   logic            bt_bad;

   fc_decode u_fc (
      .valid   (fc_valid),
      .code    (fc_code),
      .hit     (fc_hit),
      .ack_req (ack_req)
   );

   bt_parser u_bt (
      .clk   (clk),
      .rst_n (rst_n),
      .valid (pkt_valid),
      .first (pkt_first),
      .word  (pkt_word),
      .set   (bt_set),
      .bad   (bt_bad),
      .nib   (port_nib)
   );

   if (AUTO_ACK) begin : g_ack
      ack_gen u_ack (
         .clk   (clk),
         .rst_n (rst_n),
         .trig  (ack_req && !echo_off),
         .code  (fc_code),
         .valid (ack_valid),
         .word  (ack_word)
      );
   end else begin : g_no_ack
      assign ack_valid = 1'b0;
      assign ack_word  = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fc_pend   <= '0;
         bt_pend   <= '0;
         gate_open <= 1'b0;
         bad_count <= '0;
      end else begin
         fc_pend <= (fc_pend & ~fc_clr) | fc_hit;
         bt_pend <= (bt_pend & ~bt_clr) | bt_set;
         if (fc_hit[FC_GATE_ON])
            gate_open <= 1'b1;
         else if (fc_hit[FC_GATE_OFF])
            gate_open <= 1'b0;
         if (bt_bad && bad_count != CNT_MAX)
            bad_count <= bad_count + 1'b1;
      end
   end

   for (genvar i = 0; i < FC_N; i++) begin : g_fc_chk
      // R9
      fc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (fc_pend[i] && !fc_clr[i]) |=> fc_pend[i]);
   end
   for (genvar j = 0; j < BT_N; j++) begin : g_bt_chk
      // R9
      bt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bt_pend[j] && !bt_clr[j]) |=> bt_pend[j]);
   end

   // R2
   gate_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fc_valid && fc_code == 8'h42) |=> gate_open);
   // R2
   gate_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fc_valid && fc_code == 8'h62) |=> !gate_open);
   // R8
   bad_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (bad_count >= $past(bad_count)));
   // R3
   reset_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fc_valid && fc_code == 8'h21) |=> !(ack_valid && ack_word == 16'hBABA));
endmodule

// File: tb/cmd_decoder_tb.sv
module cmd_decoder_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fc_valid = 1'b0;
   logic [7:0]  fc_code = '0;
   logic        echo_off = 1'b0;
   logic        pkt_valid = 1'b0;
   logic        pkt_first = 1'b0;
   logic [15:0] pkt_word = '0;
   logic [5:0]  fc_clr = '0;
   logic [10:0] bt_clr = '0;
   logic [5:0]  fc_pend;
   logic [10:0] bt_pend;
   logic        gate_open;
   logic [3:0]  port_nib;
   logic [7:0]  bad_count;
   logic        ack_valid;
   logic [15:0] ack_word;

   int n_chk = 0;
   int n_bad = 0;
   logic [5:0]  m_fc = '0;
   logic [10:0] m_bt = '0;
   logic        m_gate = 1'b0;
   logic [3:0]  m_nib = '0;
   int          m_badc = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   cmd_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .fc_valid(fc_valid), .fc_code(fc_code), .echo_off(echo_off),
      .pkt_valid(pkt_valid), .pkt_first(pkt_first), .pkt_word(pkt_word),
      .fc_clr(fc_clr), .bt_clr(bt_clr), .fc_pend(fc_pend), .bt_pend(bt_pend),
      .gate_open(gate_open), .port_nib(port_nib), .bad_count(bad_count),
      .ack_valid(ack_valid), .ack_word(ack_word)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int fc_idx(input logic [7:0] c);
      case (c)
         8'h21: return 0;
         8'h22: return 1;
         8'h42: return 2;
         8'h62: return 3;
         8'h6F: return 4;
         8'h8F: return 5;
         default: return -1;
      endcase
   endfunction

   function automatic logic [10:0] bt_map(input logic [15:0] m, input logic [15:0] d);
      logic [10:0] r = '0;
      if (m == 16'h0004) r[4:0] = {d[7], d[3:0]};
      else if (m == 16'h0006) r[5] = d[0];
      else if (m == 16'h0012) r[7:6] = d[1:0];
      else if (m == 16'h001C) r[10:8] = d[2:0];
      return r;
   endfunction

   task automatic check_state(input string tag);
      chk(fc_pend == m_fc, {tag, " fc_pend"}, 32'(fc_pend), 32'(m_fc));
      chk(bt_pend == m_bt, {tag, " bt_pend"}, 32'(bt_pend), 32'(m_bt));
      chk(gate_open == m_gate, {tag, " gate"}, 32'(gate_open), 32'(m_gate));
      chk(bad_count == 8'(m_badc), {tag, " bad_count"}, 32'(bad_count), 32'(m_badc));
   endtask

   task automatic send_fc(input logic [7:0] code, input bit eoff);
      int  idx = fc_idx(code);
      bit  exp_ack = (idx > 0) && !eoff;
      string tag = (idx < 0) ? "R5" : (eoff ? "R4" : "R1");
      string atag = eoff ? "R4 ack" : ((idx < 0) ? "R5 ack" : "R3 ack");
      @(negedge clk);
      fc_valid = 1'b1; fc_code = code; echo_off = eoff;
      @(negedge clk);
      fc_valid = 1'b0; echo_off = 1'b0;
      if (idx >= 0) m_fc[idx] = 1'b1;
      if (idx == 2) m_gate = 1'b1;
      if (idx == 3) m_gate = 1'b0;
      check_state(tag);
      chk(ack_valid == exp_ack, atag, 32'(ack_valid), 32'(exp_ack));
      if (exp_ack) chk(ack_word == 16'hBABA, "R3 ack id", 32'(ack_word), 32'hBABA);
      @(negedge clk);
      if (exp_ack) chk(ack_valid && ack_word == {8'h00, code}, "R3 ack code",
                       32'({ack_valid, ack_word}), 32'({1'b1, 8'h00, code}));
      @(negedge clk);
      chk(!ack_valid, "R3 ack end", 32'(ack_valid), 32'h0);
   endtask

   task automatic send_pkt(input logic [15:0] w0, input logic [15:0] w2, input logic [15:0] w3,
                           input logic [15:0] w4, input string tag);
      logic [15:0] w [5];
      w[0] = w0; w[1] = 16'h1234; w[2] = w2; w[3] = w3; w[4] = w4;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         pkt_valid = 1'b1; pkt_first = (i == 0); pkt_word = w[i];
      end
      @(negedge clk);
      pkt_valid = 1'b0; pkt_first = 1'b0;
      m_nib = w0[15:12];
      if (w0[11:0] == 12'h002) begin
         if (w3 != 16'h0001 || $countones(w4) != 1) begin
            if (m_badc < 255) m_badc++;
         end else m_bt = m_bt | bt_map(w2, w4);
      end
      check_state(tag);
      chk(port_nib == m_nib, "R7 port_nib", 32'(port_nib), 32'(m_nib));
   endtask

   task automatic clear(input logic [5:0] fcv, input logic [10:0] btv);
      @(negedge clk);
      fc_clr = fcv; bt_clr = btv;
      @(negedge clk);
      fc_clr = '0; bt_clr = '0;
      m_fc = m_fc & ~fcv;
      m_bt = m_bt & ~btv;
      check_state("R9 clear");
   endtask

   localparam logic [7:0]  CODE_POOL [9] = '{8'h21, 8'h22, 8'h42, 8'h62, 8'h6F, 8'h8F, 8'h43, 8'h23, 8'h00};
   localparam logic [15:0] MOD_POOL  [6] = '{16'h0004, 16'h0006, 16'h0012, 16'h001C, 16'h000A, 16'h000E};

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int seed = 13;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_state("R9 reset");
      chk(!ack_valid, "R3 reset ack", 32'(ack_valid), 32'h0);

      // directed fast commands
      send_fc(8'h21, 1'b0);            // R3: reset gives no ack
      send_fc(8'h42, 1'b0);            // R2 open
      send_fc(8'h62, 1'b0);            // R2 close
      send_fc(8'h22, 1'b1);            // R4 echo off
      send_fc(8'h55, 1'b0);            // R5 unknown
      send_fc(8'h8F, 1'b0);
      // directed packets
      send_pkt(16'hA002, 16'h0004, 16'h0001, 16'h0080, "R6 reset bit7 with R7 nibble");
      send_pkt(16'h0002, 16'h001C, 16'h0001, 16'h0004, "R6 bank3");
      send_pkt(16'h3002, 16'h0012, 16'h0001, 16'h0000, "R8 zero bits");
      send_pkt(16'h0002, 16'h0012, 16'h0001, 16'h0003, "R8 two bits");
      send_pkt(16'h0002, 16'h0006, 16'h0002, 16'h0001, "R8 size two");
      send_pkt(16'h0001, 16'h0006, 16'h0001, 16'h0001, "R10 other type");
      send_pkt(16'h0002, 16'h0006, 16'h0001, 16'h0100, "R11 bit outside mask");
      send_pkt(16'h0002, 16'h000A, 16'h0001, 16'h0001, "R11 unknown modifier");
      clear(6'h3F, 11'h7FF);

      // R9: set and clear in the same cycle leaves the bit set
      @(negedge clk);
      fc_valid = 1'b1; fc_code = 8'h6F; fc_clr = 6'h3F;
      @(negedge clk);
      fc_valid = 1'b0; fc_clr = '0;
      m_fc = 6'b010000;
      check_state("R9 set wins");
      repeat (3) @(negedge clk);

      // random mix
      for (int it = 0; it < 300; it++) begin
         int op = int'($urandom_range(0, 3));
         if (op == 0) begin
            send_fc(CODE_POOL[$urandom_range(0, 8)], ($urandom_range(0, 4) == 0));
         end else if (op == 1) begin
            logic [15:0] d = ($urandom_range(0, 2) != 0) ? (16'h1 << $urandom_range(0, 15))
                                                          : 16'($urandom);
            logic [15:0] sz = ($urandom_range(0, 5) != 0) ? 16'h0001 : 16'($urandom_range(0, 3));
            logic [15:0] t0 = {4'($urandom), 12'h002};
            send_pkt(t0, MOD_POOL[$urandom_range(0, 5)], sz, d, "R6 random packet");
         end else if (op == 2) begin
            send_pkt({4'($urandom), 12'($urandom_range(3, 4095))}, MOD_POOL[$urandom_range(0, 3)],
                     16'h0001, 16'h0001, "R10 random other type");
         end else begin
            clear(6'($urandom), 11'($urandom));
         end
      end

      // R8 saturation
      for (int k = 0; k < 260; k++) begin
         send_pkt(16'h0002, 16'h0004, 16'h0001, 16'h0000, "R8 saturate");
      end
      chk(bad_count == 8'hFF, "R8 saturated", 32'(bad_count), 32'hFF);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule